// File: doc/BRIEF.md
# Receive Line-Rate Change Controller

This block manages run-time changes of the receive serial clock divider. A 2-bit rate-select input is combined with a static divider parameter to give the active divide value: 1, 2 or 4. Some select codes force a fixed divide. One code defers to the parameter.

Any change on the select starts a rate-change event. The block then waits for a programmable number of user-clock cycles. At the end it raises two one-cycle pulses in the same cycle: a done pulse and a status pulse in the style used by PCIe. The committed divider is published at that moment. A build-time switch lets the block hold the receive elastic-buffer reset for the whole event. Everything runs in a single user clock domain. Clock generation and the buffer itself are outside the block.

Top module: `rx_rate_ctrl`

## Requirements
- R1: Select code 2'b01 gives divide-by-4, 2'b10 gives divide-by-2 and 2'b11 gives divide-by-1. `div_o` carries the plain binary divide value (3'd4, 3'd2, 3'd1).
- R2: Select code 2'b00 gives the divide value of parameter STATIC_DIV. The parameter may only be 1, 2 or 4.
- R3: Every change of `rate_sel_i` relative to its value at the previous clock edge starts a rate-change event. With no change, `done_o` stays low.
- R4: `done_o` is high for exactly one cycle per completed event.
- R5: The change is captured at clock edge E0. `done_o` is high in the cycle that follows edge E0+XFER_CYCLES.
- R6: `status_o` pulses in exactly the same cycles as `done_o`.
- R7: With BUF_RST_EN=1, `buf_rst_o` is high from edge E0 through the cycle in which `done_o` is high. With BUF_RST_EN=0 it is never high.
- R8: A change during an event restarts the wait. Only one done pulse follows, XFER_CYCLES after the last change, and it carries the last value.
- R9: `div_o` changes only in the cycle in which `done_o` is high. During reset, and before the first clock edge after reset, it equals the decode of the current `rate_sel_i`.
- R10: Reset aborts a pending event. No done pulse follows it, and `buf_rst_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 2 | Rate-select code |
| div_o | output | 3 | Active divide value (1, 2 or 4) |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 1 | One-cycle PCIe-style status pulse |
| buf_rst_o | output | 1 | Elastic-buffer reset during an event |

## Verification
A corrupted countdown shows up as a done pulse that lands early or late against the change-capture edge, checked in the very cycle it is due. A lost or stale held select shows up when the divider is committed, as a wrong `div_o` in the done cycle. A stuck busy state shows up as `buf_rst_o` staying high past the done cycle, or as a missing pulse. Both are caught one cycle after the expected pulse. Any drift of `div_o` outside a done cycle is flagged on the first cycle it occurs.

// File: rtl/rx_rate_pkg.sv
`timescale 1ns/1ps
package rx_rate_pkg;
  typedef logic [2:0] div_t;

  typedef enum logic [1:0] {
    SEL_STATIC = 2'b00,
    SEL_DIV4   = 2'b01,
    SEL_DIV2   = 2'b10,
    SEL_DIV1   = 2'b11
  } rate_sel_e;

  function automatic div_t sel_to_div(input logic [1:0] sel, input int unsigned static_div);
    unique case (rate_sel_e'(sel))
      SEL_DIV4: return div_t'(4);
      SEL_DIV2: return div_t'(2);
      SEL_DIV1: return div_t'(1);
      default:  return div_t'(static_div);
    endcase
  endfunction
endpackage

// File: rtl/rx_rate_decode.sv
`timescale 1ns/1ps
module rx_rate_decode
  import rx_rate_pkg::*;
#(
  parameter int unsigned STATIC_DIV = 2
) (
  input  logic [1:0] sel_i,
  output div_t       div_o
);
  always_comb div_o = sel_to_div(sel_i, STATIC_DIV);
endmodule

// File: rtl/rx_rate_edge.sv
`timescale 1ns/1ps
module rx_rate_edge #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             init_o,
  output logic             change_o
);
  logic [SEL_W-1:0] sel_q;
  logic             init_q;

  // first edge after reset only samples, never reports a change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      init_q <= 1'b1;
    end else begin
      sel_q  <= sel_i;
      init_q <= 1'b0;
    end
  end

  assign sel_o    = sel_q;
  assign init_o   = init_q;
  assign change_o = !init_q && (sel_i != sel_q);
endmodule

// File: rtl/rx_rate_timer.sv
`timescale 1ns/1ps
module rx_rate_timer #(
  parameter int unsigned XFER_CYCLES = 24,
  localparam int unsigned CNT_W = $clog2(XFER_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  // restart wins over expiry in the same cycle
  assign fire_o = busy_q && !start_i && (cnt_q == CNT_W'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(XFER_CYCLES);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      else                    cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rx_rate_ctrl.sv
`timescale 1ns/1ps
module rx_rate_ctrl
  import rx_rate_pkg::*;
#(
  parameter int unsigned STATIC_DIV  = 2,
  parameter int unsigned XFER_CYCLES = 24,
  parameter bit          BUF_RST_EN  = 1'b1,
  localparam int unsigned SEL_W = 2,
  localparam int unsigned DIV_W = $bits(div_t)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic [DIV_W-1:0] div_o,
  output logic             done_o,
  output logic             status_o,
  output logic             buf_rst_o
);
  logic [SEL_W-1:0] held_sel;
  logic             init, change, busy, fire;
  div_t             live_div, held_div, div_q;
  logic             done_q, status_q;

  rx_rate_edge #(.SEL_W(SEL_W)) i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (rate_sel_i),
    .sel_o   (held_sel),
    .init_o  (init),
    .change_o(change)
  );

  rx_rate_timer #(.XFER_CYCLES(XFER_CYCLES)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(change),
    .busy_o (busy),
    .fire_o (fire)
  );

  rx_rate_decode #(.STATIC_DIV(STATIC_DIV)) i_dec_live (
    .sel_i(rate_sel_i),
    .div_o(live_div)
  );

  rx_rate_decode #(.STATIC_DIV(STATIC_DIV)) i_dec_held (
    .sel_i(held_sel),
    .div_o(held_div)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= div_t'(1);
      done_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      done_q   <= fire;
      status_q <= fire;
      if (init)      div_q <= live_div;
      else if (fire) div_q <= held_div;
    end
  end

  // until the first edge after reset the divider follows the select directly
  assign div_o    = init ? live_div : div_q;
  assign done_o   = done_q;
  assign status_o = status_q;

  if (BUF_RST_EN) begin : g_buf_rst
    assign buf_rst_o = busy | done_q;
  end else begin : g_no_buf_rst
    assign buf_rst_o = 1'b0;
  end
endmodule

// File: rtl/rx_rate_ctrl_chk.sv
`timescale 1ns/1ps
module rx_rate_ctrl_chk #(
  parameter int unsigned STATIC_DIV  = 2,
  parameter int unsigned XFER_CYCLES = 24,
  parameter bit          BUF_RST_EN  = 1'b1,
  localparam int unsigned GAP_W = $clog2(XFER_CYCLES + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] rate_sel_i,
  input logic [2:0] div_o,
  input logic       done_o,
  input logic       status_o,
  input logic       buf_rst_o
);
  logic             seen_q, pend_q;
  logic [1:0]       prev_q;
  logic [GAP_W-1:0] gap_q;
  logic             chg;

  assign chg = seen_q && (rate_sel_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      pend_q <= 1'b0;
      prev_q <= '0;
      gap_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      prev_q <= rate_sel_i;
      if (chg) begin
        pend_q <= 1'b1;
        gap_q  <= '0;
      end else begin
        if (done_o) pend_q <= 1'b0;
        if (gap_q != GAP_W'(XFER_CYCLES + 1)) gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  p_div_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ($countones(div_o) == 1));

  p_done_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pend_q);

  p_done_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (gap_q == GAP_W'(XFER_CYCLES)));

  p_status_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == done_o);

  p_bufrst_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (buf_rst_o == BUF_RST_EN));

  p_bufrst_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |-> !buf_rst_o);

  p_div_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !done_o) |-> (div_o == $past(div_o)));
endmodule

bind rx_rate_ctrl rx_rate_ctrl_chk #(
  .STATIC_DIV (STATIC_DIV),
  .XFER_CYCLES(XFER_CYCLES),
  .BUF_RST_EN (BUF_RST_EN)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rate_sel_i(rate_sel_i),
  .div_o     (div_o),
  .done_o    (done_o),
  .status_o  (status_o),
  .buf_rst_o (buf_rst_o)
);

// File: tb/test_rx_rate_ctrl.sv
`timescale 1ns/1ps
module test_rx_rate_ctrl;
  localparam int X = 5;

  typedef struct {
    int       start;
    int       due;
    logic [2:0] div_a;
    logic [2:0] div_b;
    bit       stat;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b11;
  logic [2:0] div_a, div_b;
  logic       done_a, done_b, stat_a, stat_b, buf_a, buf_b;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  item_t q[$];
  logic [2:0] last_a, last_b;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_rate_ctrl #(.STATIC_DIV(2), .XFER_CYCLES(X), .BUF_RST_EN(1'b1)) i_rx_rate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(sel),
    .div_o(div_a), .done_o(done_a), .status_o(stat_a), .buf_rst_o(buf_a)
  );

  rx_rate_ctrl #(.STATIC_DIV(4), .XFER_CYCLES(X), .BUF_RST_EN(1'b0)) i_rx_rate_ctrl_b (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(sel),
    .div_o(div_b), .done_o(done_b), .status_o(stat_b), .buf_rst_o(buf_b)
  );

  function automatic logic [2:0] bdiv(input logic [1:0] s, input int st);
    case (s)
      2'b01:   return 3'd4;
      2'b10:   return 3'd2;
      2'b11:   return 3'd1;
      default: return 3'(st);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%0d exp=%0d", req, cyc, act, exp);
    end
  endtask

  // driver: pushes the expected completion for each change (R3, R8)
  task automatic set_sel(input logic [1:0] v);
    item_t it;
    int e;
    @(negedge clk); #1;
    if (v != sel) begin
      e = cyc + 1;
      while (q.size() > 0 && q[$].due >= e) void'(q.pop_back());
      it.start = e;
      it.due   = e + X;
      it.div_a = bdiv(v, 2);
      it.div_b = bdiv(v, 4);
      it.stat  = (v == 2'b00);
      q.push_back(it);
    end
    sel = v;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(div_a == bdiv(sel, 2), "R9", div_a, bdiv(sel, 2));
      chk(div_b == bdiv(sel, 4), "R9", div_b, bdiv(sel, 4));
      chk(!done_a && !buf_a, "R10", {done_a, buf_a}, 0);
      last_a = bdiv(sel, 2);
      last_b = bdiv(sel, 4);
    end else begin
      automatic bit exp_buf = (q.size() > 0) && (q[0].start <= cyc) && (cyc <= q[0].due);
      chk(stat_a == done_a, "R6", stat_a, done_a);
      chk(stat_b == done_b, "R6", stat_b, done_b);
      chk(buf_a == exp_buf, "R7", buf_a, exp_buf);
      chk(buf_b == 1'b0, "R7", buf_b, 0);
      chk(done_b == done_a, "R5", done_b, done_a);
      if (done_a) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4", done_a, 0); // pulse without event, or R3 spurious
        end else begin
          automatic item_t it = q.pop_front();
          chk(it.due == cyc, "R5", cyc, it.due);
          chk(div_a == it.div_a, it.stat ? "R2" : "R1", div_a, it.div_a);
          chk(div_b == it.div_b, it.stat ? "R2" : "R1", div_b, it.div_b);
          last_a = div_a;
          last_b = div_b;
        end
      end else begin
        chk(div_a == last_a, "R9", div_a, last_a);
        chk(div_b == last_b, "R9", div_b, last_b);
        if (q.size() > 0 && q[0].due < cyc) begin
          chk(1'b0, "R5", 0, q[0].due);
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    wait_n(3);                 // R3: no change, no pulse
    set_sel(2'b01); wait_n(8); // R1
    set_sel(2'b10); wait_n(8);
    set_sel(2'b00); wait_n(8); // R2
    set_sel(2'b11); wait_n(8);
    // R8: restarts, single pulse with last value
    set_sel(2'b01); wait_n(2);
    set_sel(2'b10); wait_n(3);
    set_sel(2'b00); wait_n(10);
    // R8: change lands on the expiry edge
    set_sel(2'b11); wait_n(X - 1);
    set_sel(2'b01); wait_n(10);
    // change and return to the same code still completes
    set_sel(2'b10); wait_n(1);
    set_sel(2'b01); wait_n(10);
    // R10: reset mid-event
    set_sel(2'b10); wait_n(2);
    do_reset();
    wait_n(10);
    set_sel(2'b00); wait_n(10);
    chk(q.size() == 0, "R4", q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R5 act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule